// File: doc/BRIEF.md
# SAR ADC Bus Controller

This block is a memory-mapped sequencer for a successive-approximation analog-to-digital converter. Software reaches it through a simple APB-style register port holding four word registers: the conversion result, a status word, a control word and a settle-delay word. The analog parts (comparator, trial DAC and input multiplexer) stay outside. The block drives them through a trial-code bus and a channel-select bus, and it reads back one comparator bit.

To take a sample, software writes the control word with the power bit set, a channel number and, if wanted, the interrupt enable. The block latches the channel and waits the programmed number of clocks so the analog front end can settle. It then resolves one result bit per clock, from the most significant bit down. When the last bit is resolved, the block stores the result, sets the interrupt status and, if enabled, raises the interrupt line. Writing an all-zero word to the control register acknowledges the interrupt and powers the converter down. The same write also aborts a conversion that is still in flight.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Read map, decoded from `paddr`: 0x0 gives the result in bits [RES_BITS-1:0]. 0x4 gives busy in bit 0. 0x8 gives the control word: channel in [2:0], power in bit 3, interrupt enable in bit 5, interrupt status in bit 6. 0xC gives the settle delay in [5:0]. Every other bit and every other address reads 0.
- R2: After reset, every register reads 0, and `busy`, `pwr_on`, `irq`, `trial_code` and `ch_sel` are 0.
- R3: A control write is a write cycle (`psel`, `penable`, `pwrite` all high) to address 0x8. When the block is idle, a nonzero control write with bit 3 = 1 and a channel below NUM_CH starts a conversion. Busy reads 1 from the cycle after the write edge.
- R4: Let D be the delay register value. The first trial code, with only the MSB set, appears D+1 clock edges after the write edge. After RES_BITS trial cycles, busy clears and the status bit sets, D+1+RES_BITS edges after the write.
- R5: Bits are tested from MSB to LSB, one per clock. A bit is kept when `cmp_in` is 1, which means the input is at or above the trial level. For a monotonic comparator, the stored result equals the input level.
- R6: The result register changes only when a conversion completes. It keeps its value through cancels and through other writes.
- R7: At completion the interrupt status (control bit 6) sets. `irq` equals the status AND the enable (control bit 5).
- R8: An all-zero control write, in any state, clears power, enable, channel and status, and returns the sequencer to idle. Busy reads 0 on the next cycle.
- R9: A nonzero control write while busy is ignored. The control word and `ch_sel` are unchanged, and the running conversion finishes normally.
- R10: When idle, a nonzero control write with bit 3 = 1 and a channel of NUM_CH or above is ignored entirely. A nonzero idle write with bit 3 = 0 updates the channel and enable fields, clears the status and starts nothing. Writes to bit 6 never set the status.
- R11: `ch_sel` takes the channel at start and stays stable while busy.
- R12: `pwr_on` follows the control power bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the converter |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe |
| paddr | input | 4 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, decoded from `paddr` |
| cmp_in | input | 1 | Comparator: input at or above trial level |
| trial_code | output | RES_BITS | Code driven to the trial DAC |
| ch_sel | output | 3 | Analog multiplexer channel |
| pwr_on | output | 1 | Converter power enable |
| irq | output | 1 | Interrupt request |

## Verification
The in-RTL properties check, on every cycle, that `ch_sel` holds while busy, that a zero write cancels and powers down, that writes while busy leave the control fields alone, that the result register moves only on the final trial, and that the sequence moves from settle into the MSB trial and from the final trial into done. Only the bench scenarios can show that the stored value matches the analog level across many random levels, channels and delays. The same holds for the exact edge count from the write to the first trial and to completion, the handling of invalid channels, and the read-back layout of each register.

// File: rtl/sar_adc_ctrl.sv
`timescale 1ns/1ps
module sar_adc_ctrl #(
  parameter int RES_BITS = 10,
  parameter int NUM_CH   = 6,
  parameter int DLY_BITS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [3:0]          paddr,
  input  logic [31:0]         pwdata,
  output logic [31:0]         prdata,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] trial_code,
  output logic [2:0]          ch_sel,
  output logic                pwr_on,
  output logic                irq
);
  localparam int IDX_W = $clog2(RES_BITS + 1);
  localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_CONV} state_t;

  state_t               state;
  logic [DLY_BITS-1:0]  cnt, dly_q;
  logic [IDX_W-1:0]     bit_idx;
  logic [RES_BITS-1:0]  trial, result, kept, next_trial;
  logic [2:0]           ch_reg, ch_lat;
  logic                 pwr_q, ie_q, st_q;

  wire wr      = psel & penable & pwrite;
  wire wr_ctrl = wr && (paddr == 4'h8);
  wire wr_dly  = wr && (paddr == 4'hC);
  wire zero_wr = wr_ctrl && (pwdata == 32'h0);
  wire busy    = (state != S_IDLE);
  wire ch_ok   = int'(pwdata[2:0]) < NUM_CH;
  wire accept  = wr_ctrl && !zero_wr && !busy && !(pwdata[3] && !ch_ok);
  wire start   = accept && pwdata[3];
  wire last    = (state == S_CONV) && (bit_idx == '0);

  always_comb begin
    kept = trial;
    if (!cmp_in) kept[bit_idx] = 1'b0;
    next_trial = kept;
    if (bit_idx != '0) next_trial[bit_idx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      dly_q   <= '0;
      bit_idx <= '0;
      trial   <= '0;
      result  <= '0;
      ch_reg  <= '0;
      ch_lat  <= '0;
      pwr_q   <= 1'b0;
      ie_q    <= 1'b0;
      st_q    <= 1'b0;
    end else begin
      if (wr_dly) dly_q <= pwdata[DLY_BITS-1:0];
      if (zero_wr) begin
        pwr_q  <= 1'b0;
        ie_q   <= 1'b0;
        st_q   <= 1'b0;
        ch_reg <= '0;
        state  <= S_IDLE;
      end else begin
        if (accept) begin
          ch_reg <= pwdata[2:0];
          pwr_q  <= pwdata[3];
          ie_q   <= pwdata[5];
          st_q   <= 1'b0;
        end
        if (start) begin
          state  <= S_SETTLE;
          cnt    <= dly_q;
          ch_lat <= pwdata[2:0];
        end
        case (state)
          S_SETTLE: begin
            if (cnt == '0) begin
              state   <= S_CONV;
              bit_idx <= IDX_W'(RES_BITS - 1);
              trial   <= MSB_ONLY;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          S_CONV: begin
            trial <= next_trial;
            if (bit_idx == '0) begin
              result <= next_trial;
              st_q   <= 1'b1;
              state  <= S_IDLE;
            end else begin
              bit_idx <= bit_idx - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      4'h0: prdata[RES_BITS-1:0] = result;
      4'h4: prdata[0] = busy;
      4'h8: begin
        prdata[2:0] = ch_reg;
        prdata[3]   = pwr_q;
        prdata[5]   = ie_q;
        prdata[6]   = st_q;
      end
      4'hC: prdata[DLY_BITS-1:0] = dly_q;
      default: ;
    endcase
  end

  assign trial_code = trial;
  assign ch_sel     = ch_lat;
  assign pwr_on     = pwr_q;
  assign irq        = st_q & ie_q;

  p_chsel_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ch_sel));
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    zero_wr |=> (!busy && !pwr_on && !irq));
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && busy && !zero_wr) |=> ($stable(pwr_q) && $stable(ie_q) && $stable(ch_reg)));
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(result));
  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !zero_wr) |=> (!busy && st_q));
  p_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SETTLE && cnt == '0 && !zero_wr) |=> (state == S_CONV && trial_code == MSB_ONLY));
endmodule

// File: tb/sim_sar_adc_ctrl.sv
`timescale 1ns/1ps
module sim_sar_adc_ctrl;
  localparam int N   = 10;
  localparam int NCH = 6;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [3:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic cmp_in;
  logic [N-1:0] trial_code, vin = 0;
  logic [2:0] ch_sel;
  logic pwr_on, irq;
  int checks = 0, errs = 0;

  always #2.5 clk = ~clk;
  assign cmp_in = (vin >= trial_code);

  sar_adc_ctrl #(.RES_BITS(N), .NUM_CH(NCH), .DLY_BITS(6)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cmp_in(cmp_in),
    .trial_code(trial_code), .ch_sel(ch_sel), .pwr_on(pwr_on), .irq(irq));

  function automatic logic [31:0] ctrl_word(int ch, bit pwr, bit ie, bit st);
    return 32'(ch & 7) | (32'(pwr) << 3) | (32'(ie) << 5) | (32'(st) << 6);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    paddr = a; #0.5; d = prdata;
  endtask

  task automatic run_conv(int ch, bit ie, int dly, logic [N-1:0] level);
    logic [31:0] d;
    wr(4'hC, 32'(dly));
    vin = level;
    wr(4'h8, ctrl_word(ch, 1, ie, 0));
    rd(4'h4, d); chk("R3 busy after start", d, 32'h1);
    repeat (dly + 1) @(posedge clk);
    @(negedge clk);
    chk("R4 msb trial", 32'(trial_code), 32'(1 << (N-1)));
    chk("R11 ch_sel latched", 32'(ch_sel), 32'(ch));
    repeat (N - 1) @(posedge clk);
    @(negedge clk);
    rd(4'h4, d); chk("R4 busy before last", d, 32'h1);
    @(posedge clk); @(negedge clk);
    rd(4'h4, d); chk("R4 busy cleared", d, 32'h0);
    rd(4'h0, d); chk("R5 result", d, 32'(level));
    rd(4'h8, d); chk("R7 status set", d, ctrl_word(ch, 1, ie, 1));
    chk("R7 irq gate", 32'(irq), 32'(ie));
    chk("R12 power on", 32'(pwr_on), 32'h1);
  endtask

  initial begin
    #500us;
    errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    logic [31:0] d, keep;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), d); chk("R2 reset reg", d, 32'h0);
    end
    chk("R2 reset irq", 32'(irq), 0);
    chk("R2 reset power", 32'(pwr_on), 0);
    chk("R2 reset trial", 32'(trial_code), 0);

    run_conv(0, 1, 0, '0);
    wr(4'h8, 32'h0);
    chk("R8 irq cleared", 32'(irq), 0);
    chk("R8 power down", 32'(pwr_on), 0);
    run_conv(NCH - 1, 1, 63, {N{1'b1}});
    rd(4'h0, d); chk("R1 upper bits zero", d & ~32'((1 << N) - 1), 32'h0);
    rd(4'hC, d); chk("R1 delay readback", d, 32'd63);
    rd(4'h2, d); chk("R1 unmapped address", d, 32'h0);
    wr(4'h8, 32'h0);

    for (int i = 0; i < 30; i++) begin
      run_conv($urandom % NCH, 1'($urandom), $urandom % 12, N'($urandom));
      wr(4'h8, 32'h0);
    end

    run_conv(2, 1, 3, 10'd345);
    rd(4'h0, keep);
    wr(4'hC, 32'd20);
    vin = 10'd77;
    wr(4'h8, ctrl_word(3, 1, 1, 0));
    repeat (5) @(posedge clk);
    wr(4'h8, 32'h0);
    rd(4'h4, d); chk("R8 cancel idle", d, 32'h0);
    repeat (60) @(negedge clk);
    rd(4'h0, d); chk("R6 result held after cancel", d, keep);
    rd(4'h8, d); chk("R8 ctrl cleared", d, 32'h0);

    wr(4'hC, 32'd8);
    vin = 10'd600;
    wr(4'h8, ctrl_word(1, 1, 0, 0));
    wr(4'h8, ctrl_word(4, 1, 1, 0));
    rd(4'h8, d); chk("R9 ctrl unchanged", d, ctrl_word(1, 1, 0, 0));
    chk("R9 ch_sel unchanged", 32'(ch_sel), 32'd1);
    for (int k = 0; k < 200; k++) begin
      rd(4'h4, d);
      if (d == 0) break;
      @(negedge clk);
    end
    rd(4'h0, d); chk("R9 conversion finished", d, 32'd600);
    chk("R7 irq off when disabled", 32'(irq), 0);
    wr(4'h8, 32'h0);

    wr(4'h8, ctrl_word(6, 1, 1, 0));
    rd(4'h4, d); chk("R10 invalid channel no start", d, 32'h0);
    rd(4'h8, d); chk("R10 invalid channel ignored", d, 32'h0);
    wr(4'h8, ctrl_word(3, 0, 1, 1));
    rd(4'h8, d); chk("R10 idle write no power", d, ctrl_word(3, 0, 1, 0));
    rd(4'h4, d); chk("R10 no conversion", d, 32'h0);
    chk("R12 power off", 32'(pwr_on), 0);
    chk("R11 ch_sel only at start", 32'(ch_sel), 32'd1);
    wr(4'h8, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule